// File: doc/BRIEF.md
# PCM Sample Unpacker

The block holds a small byte queue filled one byte per clock from a producer, and drains it on each sample tick into one stereo pair of signed 16-bit samples. A two-bit format code chooses how the bytes ahead of the read point are grouped into a frame. The frame can be mono or stereo, and each sample can be 8 or 16 bits wide. Eight-bit data arrives unsigned and leaves in signed 16-bit form. Mono data is copied to both channels.

A tick consumes a frame only when the queue already holds every byte of that frame. If the queue is short, or the channel is switched off, the tick produces a silent pair and the queued bytes stay where they are. The result registers load only on a tick. A one-clock strobe marks each load, so a downstream mixer sees exactly one pair per tick.

Top module: `pcm_unpack`

## Requirements
- R1: Format code 2'b00 (mono 8-bit) consumes one byte b per frame. It drives both outputs with {~b[7], b[6:0], 8'h00}.
- R2: Format code 2'b01 (stereo 8-bit) consumes two bytes per frame. The older byte goes to the left output and the newer byte to the right, each converted as in R1.
- R3: Format code 2'b10 (mono 16-bit) consumes two bytes per frame. The older byte is the low half and the newer byte the high half. The same value goes to both outputs.
- R4: Format code 2'b11 (stereo 16-bit) consumes four bytes per frame. Bytes 0 and 1, in queue order and low byte first, form the left sample. Bytes 2 and 3 form the right sample.
- R5: A tick with enable high drives both outputs to zero and removes no byte when the queue holds fewer bytes than the format needs. A later tick then delivers the same bytes.
- R6: A tick with enable low drives both outputs to zero and removes no byte from the queue.
- R7: The outputs change only in the cycle after a tick, and hold their value otherwise. out_valid is high for exactly the one cycle after each tick, including silent ticks.
- R8: The queue holds at most FIFO_DEPTH (32) bytes and keeps them in arrival order across pointer wrap. A write while it is full is dropped, even if a tick removes bytes in the same cycle.
- R9: After reset the outputs are zero, out_valid is low and the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Channel on; when low, ticks give silence |
| sample_tick | input | 1 | One-cycle pulse at the output sample rate |
| fmt | input | 2 | Frame format code (see R1 to R4) |
| wr_en | input | 1 | Push wr_data into the queue |
| wr_data | input | 8 | Byte to queue |
| out_left | output | 16 | Left sample, signed |
| out_right | output | 16 | Right sample, signed |
| out_valid | output | 1 | High for one cycle after each tick |

## Verification
Each tick settles at the clock edge where it is high. The new pair and the strobe appear right after that edge, and the queue level reflects the pop in the same cycle. A byte written in a cycle can be consumed by a tick one cycle later at the earliest. The bench applies inputs on the falling edge and advances a queue model at each rising edge. It compares strobe and both samples at the next falling edge, so every result is checked in the cycle it is due. Stalls on a short queue, a disabled channel, overflow drops and pointer wrap are driven directly, then mixed in a pseudo-random stretch.

// File: rtl/pcm_unpack_pkg.sv
package pcm_unpack_pkg;

   localparam int BYTE_W   = 8;
   localparam int SAMPLE_W = 2 * BYTE_W;
   localparam int PEEK_N   = 4;
   localparam int POP_W    = $clog2(PEEK_N + 1);

   typedef enum logic [1:0] {
      FMT_MONO8   = 2'b00,
      FMT_STEREO8 = 2'b01,
      FMT_MONO16  = 2'b10,
      FMT_STEREO16= 2'b11
   } pcm_fmt_e;

   // bytes a whole frame occupies in the queue
   function automatic logic [POP_W-1:0] frame_bytes(pcm_fmt_e f);
      unique case (f)
         FMT_MONO8:    return POP_W'(1);
         FMT_STEREO8:  return POP_W'(2);
         FMT_MONO16:   return POP_W'(2);
         default:      return POP_W'(4);
      endcase
   endfunction

   // unsigned byte to signed sample, byte in the upper half
   function automatic logic [SAMPLE_W-1:0] widen_u8(logic [BYTE_W-1:0] b);
      return {~b[BYTE_W-1], b[BYTE_W-2:0], {BYTE_W{1'b0}}};
   endfunction

endpackage

// File: rtl/pcm_byte_fifo.sv
module pcm_byte_fifo
   import pcm_unpack_pkg::*;
#(
   parameter int DEPTH = 32
)(
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_en,
   input  logic [BYTE_W-1:0]              wr_data,
   input  logic [POP_W-1:0]               pop_n,
   output logic [PEEK_N-1:0][BYTE_W-1:0]  peek,
   output logic [$clog2(DEPTH):0]         level
);

   localparam int AW = $clog2(DEPTH);
   localparam logic [AW:0] DEPTH_L = (AW+1)'(DEPTH);

   if ((DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("pcm_byte_fifo: DEPTH must be a power of two");
   end
   if (DEPTH < PEEK_N) begin : g_small_depth
      $error("pcm_byte_fifo: DEPTH must cover a full frame");
   end

   logic [BYTE_W-1:0] mem [DEPTH];
   logic [AW:0]       wr_ptr, rd_ptr;
   logic              full;

   assign level = wr_ptr - rd_ptr;
   assign full  = (level == DEPTH_L);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
      end else begin
         if (wr_en && !full) wr_ptr <= wr_ptr + 1'b1;
         rd_ptr <= rd_ptr + (AW+1)'(pop_n);
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en && !full) mem[wr_ptr[AW-1:0]] <= wr_data;
   end

   for (genvar k = 0; k < PEEK_N; k++) begin : g_peek
      assign peek[k] = mem[rd_ptr[AW-1:0] + AW'(k)];
   end

   // R8
   level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      level <= DEPTH_L);

   // R8
   full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && full && pop_n == '0) |=> (level == DEPTH_L));

   // R5
   pop_covered_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (AW+1)'(pop_n) <= level);

endmodule

// File: rtl/pcm_frame_decode.sv
module pcm_frame_decode
   import pcm_unpack_pkg::*;
(
   input  pcm_fmt_e                       fmt,
   input  logic [PEEK_N-1:0][BYTE_W-1:0]  bytes_in,
   output logic [POP_W-1:0]               need,
   output logic [SAMPLE_W-1:0]            left,
   output logic [SAMPLE_W-1:0]            right
);

   logic [1:0][SAMPLE_W-1:0] wide8;
   logic [1:0][SAMPLE_W-1:0] word16;

   for (genvar k = 0; k < 2; k++) begin : g_lane
      assign wide8[k]  = widen_u8(bytes_in[k]);
      assign word16[k] = {bytes_in[2*k+1], bytes_in[2*k]};
   end

   assign need = frame_bytes(fmt);

   always_comb begin
      unique case (fmt)
         FMT_MONO8:   begin left = wide8[0];  right = wide8[0];  end
         FMT_STEREO8: begin left = wide8[0];  right = wide8[1];  end
         FMT_MONO16:  begin left = word16[0]; right = word16[0]; end
         default:     begin left = word16[0]; right = word16[1]; end
      endcase
   end

endmodule

// File: rtl/pcm_unpack.sv
module pcm_unpack
   import pcm_unpack_pkg::*;
#(
   parameter int FIFO_DEPTH = 32
)(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        enable,
   input  logic        sample_tick,
   input  logic [1:0]  fmt,
   input  logic        wr_en,
   input  logic [7:0]  wr_data,
   output logic [15:0] out_left,
   output logic [15:0] out_right,
   output logic        out_valid
);

   localparam int LW = $clog2(FIFO_DEPTH) + 1;

   logic [PEEK_N-1:0][BYTE_W-1:0] head;
   logic [LW-1:0]                 level;
   logic [POP_W-1:0]              need, pop_n;
   logic [SAMPLE_W-1:0]           dec_l, dec_r;
   logic                          take;

   pcm_byte_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .pop_n   (pop_n),
      .peek    (head),
      .level   (level)
   );

   pcm_frame_decode u_dec (
      .fmt      (pcm_fmt_e'(fmt)),
      .bytes_in (head),
      .need     (need),
      .left     (dec_l),
      .right    (dec_r)
   );

   assign take  = sample_tick && enable && (level >= LW'(need));
   assign pop_n = take ? need : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_left  <= '0;
         out_right <= '0;
         out_valid <= 1'b0;
      end else begin
         out_valid <= sample_tick;
         if (sample_tick) begin
            out_left  <= take ? dec_l : '0;
            out_right <= take ? dec_r : '0;
         end
      end
   end

   // R7
   strobe_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sample_tick |=> out_valid);

   // R7
   hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sample_tick |=> (!out_valid && $stable(out_left) && $stable(out_right)));

   // R6
   disabled_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_tick && !enable) |=> (out_left == '0 && out_right == '0));

   // R1
   mono_dup_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_tick && !fmt[0]) |=> (out_left == out_right));

endmodule

// File: tb/pcm_unpack_tb_top.sv
module pcm_unpack_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b0;
   logic        sample_tick = 1'b0;
   logic [1:0]  fmt = 2'b00;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_data = 8'h00;
   logic [15:0] out_left, out_right;
   logic        out_valid;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pcm_unpack #(.FIFO_DEPTH(DEPTH)) dut_i (
      .clk(clk), .rst_n(rst_n), .enable(enable), .sample_tick(sample_tick),
      .fmt(fmt), .wr_en(wr_en), .wr_data(wr_data),
      .out_left(out_left), .out_right(out_right), .out_valid(out_valid)
   );

   // behavioural reference
   byte unsigned mq[$];
   int           el = 0, er = 0;
   bit           ev = 0;
   string        etag = "R9";

   function automatic int conv8(byte unsigned b);
      return ((b ^ 8'h80) * 256) & 16'hFFFF;
   endfunction

   always @(posedge clk) begin
      int need;
      bit was_full;
      if (!rst_n) begin
         mq.delete(); el = 0; er = 0; ev = 0; etag = "R9";
      end else begin
         was_full = (mq.size() == DEPTH);
         ev = sample_tick;
         if (sample_tick) begin
            need = (fmt == 2'b00) ? 1 : (fmt == 2'b11) ? 4 : 2;
            if (enable && mq.size() >= need) begin
               case (fmt)
                  2'b00: begin el = conv8(mq[0]); er = el; etag = "R1"; end
                  2'b01: begin el = conv8(mq[0]); er = conv8(mq[1]); etag = "R2"; end
                  2'b10: begin el = mq[1]*256 + mq[0]; er = el; etag = "R3"; end
                  default: begin el = mq[1]*256 + mq[0]; er = mq[3]*256 + mq[2]; etag = "R4"; end
               endcase
               for (int i = 0; i < need; i++) void'(mq.pop_front());
            end else begin
               el = 0; er = 0;
               etag = enable ? "R5" : "R6";
            end
         end else etag = "R7";
         if (wr_en && !was_full) mq.push_back(wr_data);
         else if (wr_en) etag = "R8";
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         checks++;
         if (out_valid !== ev || out_left !== 16'(el) || out_right !== 16'(er)) begin
            fails++;
            $display("FAIL %s: actual v=%0b l=%h r=%h expected v=%0b l=%h r=%h",
                     etag, out_valid, out_left, out_right, ev, 16'(el), 16'(er));
         end
      end
   end

   task automatic cyc(bit t, bit w, byte unsigned d);
      @(negedge clk);
      sample_tick = t; wr_en = w; wr_data = d;
   endtask

   task automatic push(byte unsigned d);
      cyc(0, 1, d);
   endtask

   task automatic tick();
      cyc(1, 0, 0);
   endtask

   task automatic finish_up();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      finish_up();
   end

   initial begin
      int nz;
      int seed;
      #(CLK_PERIOD * 3 + 2);
      // R9 reset state
      checks++;
      if (out_valid !== 1'b0 || out_left !== 16'h0 || out_right !== 16'h0) begin
         fails++;
         $display("FAIL R9: actual v=%0b l=%h r=%h expected v=0 l=0000 r=0000",
                  out_valid, out_left, out_right);
      end
      @(negedge clk); rst_n = 1'b1; enable = 1'b1;

      // R1 mono 8-bit edge values
      fmt = 2'b00;
      push(8'h00); push(8'h80); push(8'hFF); push(8'h7F);
      repeat (4) tick();
      tick();                                // R5 empty queue
      // R2 stereo 8-bit, then R5 short by one byte
      fmt = 2'b01;
      push(8'h10); push(8'hF0); push(8'h81);
      tick(); tick();
      push(8'h01); tick();
      // R3 mono 16-bit
      fmt = 2'b10;
      push(8'h34); push(8'h12); tick();
      // R4 stereo 16-bit, R5 with three of four bytes
      fmt = 2'b11;
      push(8'hCD); push(8'hAB); push(8'h01); tick();
      push(8'h80); tick();
      // R6 disabled tick keeps bytes
      push(8'h11); push(8'h22); push(8'h33); push(8'h44);
      @(negedge clk); enable = 1'b0; sample_tick = 1'b0; wr_en = 1'b0;
      tick();
      @(negedge clk); enable = 1'b1; sample_tick = 1'b0;
      tick();
      // R7 idle cycles hold outputs
      repeat (3) cyc(0, 0, 0);
      // R8 overflow: 40 writes, only 32 kept
      for (int i = 0; i < 40; i++) push(byte'(i + 1));
      nz = 0;
      for (int i = 0; i < 10; i++) begin
         tick();
         @(posedge clk); #1;
         if (out_left != 0 || out_right != 0) nz++;
      end
      checks++;
      if (nz != 8) begin
         fails++;
         $display("FAIL R8: actual frames=%0d expected frames=8", nz);
      end
      // mixed traffic across wrap
      seed = 7;
      for (int i = 0; i < 600; i++) begin
         seed = (seed * 1103515245 + 12345) & 32'h7FFFFFFF;
         @(negedge clk);
         if ((seed >> 20) % 50 == 0) fmt = 2'((seed >> 8) & 3);
         enable      = ((seed >> 11) % 9) != 0;
         sample_tick = ((seed >> 13) % 3) == 0;
         wr_en       = ((seed >> 16) % 2) == 0;
         wr_data     = 8'(seed >> 3);
      end
      @(negedge clk); sample_tick = 0; wr_en = 0;
      repeat (3) @(negedge clk);
      finish_up();
   end

endmodule